// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This block gathers the error events reported by a CAN protocol engine and turns them into software-visible state and one interrupt line. Each event type arrives as a single-cycle strobe and sets a sticky bit in an 8-bit error-factor register. Each bus-error kind sets a bit in an error-code store, and any such code also sets the bus-error factor bit. Software clears a flag by writing 0 to it. Writing 1 leaves the flag as it is, so a write of all ones except one bit clears only that bit.

The unit also keeps the transmit and receive error counters. Increment and decrement controls from the protocol engine step these counters. When a counter first rises above the warning limit (96) or the passive limit (127), the unit sets the matching factor bit. When the transmit counter first rises above 255, it sets the bus-off entry bit. A separate recovery strobe, issued when the externally run recovery sequence completes, sets the recovery bit and clears both counters.

A summary status bit is the OR over the enabled factor bits. The interrupt pin is that summary gated by one bit of the interrupt-enable register. The error-code store works in one of two modes: it either accumulates codes across events or holds only the codes of the latest event.

Top module: `can_err_irq_unit`

## Requirements
- R1: After reset, every readable register (addresses 0 to 6) reads 0 and `err_irq` is low; the code store starts in latest-only mode.
- R2: Event strobes set factor bits (address 0) one cycle later at these positions: bus lock 7, overload frame 6, receive overrun 5, recovery done 4, bus-off entry 3, error passive 2, error warning 1, bus error 0. Bits stay set until software clears them.
- R3: A write to the factor register (address 0) or to the code bits 6:0 of the code store (address 2) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When an event strobe and a software clear of the same bit fall in the same cycle, the bit is set after that cycle.
- R5: `code_stb` bit positions are: stuff 0, form 1, ACK 2, CRC 3, recessive bit 4, dominant bit 5, ACK delimiter 6. A strobed code sets the same bit of the code store, and any nonzero `code_stb` sets factor bit 0.
- R6: Bit 7 of the code store selects the mode and is written directly. When it is 1, new codes are ORed into the stored codes. When it is 0, the codes of the latest event replace the stored codes.
- R7: The transmit counter adds 8 per `tx_inc`, the receive counter adds 1 per `rx_inc`, each `*_dec` subtracts 1 and never goes below 0, and an increment and a decrement in the same cycle both apply. Reads (transmit at address 5, receive at address 6) return the count limited to 255. `ev_bo_recover` clears both counters and sets factor bit 4.
- R8: Factor bit 1 sets only in the cycle in which a counter goes from at most 96 to above 96; staying above 96 does not set it again.
- R9: Factor bit 2 sets only in the cycle in which a counter goes from at most 127 to above 127.
- R10: Factor bit 3 sets in the cycle in which the transmit counter goes from at most 255 to above 255.
- R11: Address 1 holds the factor enables, using the factor bit layout. Bit 5 of the status register (address 4, read-only) is the OR of factor AND enable. The interrupt-enable register (address 3) keeps only bit 5. `err_irq` is status bit 5 AND interrupt-enable bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 factor, 1 enable, 2 code store, 3 interrupt enable) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address (0 to 6) |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ev_bus_lock | input | 1 | Bus lock event strobe |
| ev_overload | input | 1 | Overload frame sent strobe |
| ev_rx_overrun | input | 1 | Receive overrun strobe |
| ev_bo_recover | input | 1 | Bus-off recovery finished strobe |
| code_stb | input | 7 | Bus-error code strobes |
| tx_inc | input | 1 | Transmit counter increment |
| tx_dec | input | 1 | Transmit counter decrement |
| rx_inc | input | 1 | Receive counter increment |
| rx_dec | input | 1 | Receive counter decrement |
| err_irq | output | 1 | Summary error interrupt |

## Verification
Every flag, code and counter result is due at the first clock edge after its strobe, write or step. The summary status, the interrupt and `rd_data` follow the registers with no further delay. The bench changes inputs 1 ns after a rising edge. It reads results 1 ns after the next rising edge, so it samples each value in the cycle in which that value is due. The threshold checks step a counter to the limit and read one step short of the crossing and at the crossing itself. They also check that a cleared warning does not return while the counter stays above the limit.

// File: rtl/can_err_pkg.sv
// Shared constants for the CAN error flag and interrupt unit.
// Assumes an 8-bit register width fixed by the bit layouts below.
package can_err_pkg;

    localparam int REG_W = 8;

    // Register addresses
    typedef enum logic [2:0] {
        A_FACTOR = 3'd0,
        A_ENABLE = 3'd1,
        A_CODE   = 3'd2,
        A_IER    = 3'd3,
        A_STATUS = 3'd4,
        A_TEC    = 3'd5,
        A_REC    = 3'd6
    } reg_addr_e;

    // Factor register bit positions (enable register uses the same layout)
    localparam int FB_BUSERR  = 0;
    localparam int FB_WARN    = 1;
    localparam int FB_PASSIVE = 2;
    localparam int FB_BUSOFF  = 3;
    localparam int FB_RECOVER = 4;
    localparam int FB_OVERRUN = 5;
    localparam int FB_OVERLD  = 6;
    localparam int FB_BUSLOCK = 7;

    // Code store mode bit and summary bit positions
    localparam int CODE_MODE_BIT = 7;
    localparam int CODE_N        = 7;
    localparam int IRQ_BIT       = 5;

endpackage

// File: rtl/err_counter.sv
// One error counter with threshold-crossing detection.
// Adds STEP on inc and subtracts 1 on dec (floor 0); both apply in one cycle.
// clr has priority. Crossing pulses come from the current and next value,
// so a flag register sampling them sets on the same edge as the counter.
// BUSOFF_EN selects whether the bus-off crossing is detected.
module err_counter #(
    parameter int CNT_W      = 9,
    parameter int STEP       = 1,
    parameter int WARN_LIM   = 96,
    parameter int PASS_LIM   = 127,
    parameter int BUSOFF_LIM = 255,
    parameter bit BUSOFF_EN  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             warn_rise_o,
    output logic             pass_rise_o,
    output logic             busoff_rise_o
);
    localparam logic [CNT_W:0]   STEP_W = (CNT_W+1)'(STEP);
    localparam logic [CNT_W:0]   MAX_W  = (CNT_W+1)'((1 << CNT_W) - 1);
    localparam logic [CNT_W-1:0] WARN_W = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_W = CNT_W'(PASS_LIM);
    localparam logic [CNT_W-1:0] BO_W   = CNT_W'(BUSOFF_LIM);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   tmp;

    // Next count: step up, step down with floor, saturate, clear.
    always_comb begin
        tmp = {1'b0, cnt_q};
        if (inc) tmp = tmp + STEP_W;
        if (dec && (tmp != '0)) tmp = tmp - 1'b1;
        if (tmp > MAX_W) tmp = MAX_W;
        cnt_d = clr ? '0 : tmp[CNT_W-1:0];
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o       = cnt_q;
    assign warn_rise_o = (cnt_q <= WARN_W) && (cnt_d > WARN_W);
    assign pass_rise_o = (cnt_q <= PASS_W) && (cnt_d > PASS_W);

    generate
        if (BUSOFF_EN) begin : g_bo
            assign busoff_rise_o = (cnt_q <= BO_W) && (cnt_d > BO_W);
        end else begin : g_no_bo
            assign busoff_rise_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/err_code_store.sv
// Error-code store: seven code bits plus a mode bit (bit 7).
// A write clears code bits written as 0 and loads the mode bit directly.
// Strobed codes win over a same-cycle clear. The registered mode picks
// accumulate (1) or replace (0).
module err_code_store
    import can_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CODE_N-1:0] stb,
    output logic [REG_W-1:0]  code_o,
    output logic              any_err_o
);
    logic [CODE_N-1:0] bits_q, bits_d;
    logic              mode_q, mode_d;

    // Next state: software clear and mode load, then event merge.
    always_comb begin
        bits_d = bits_q;
        mode_d = mode_q;
        if (we) begin
            bits_d = bits_q & wdata[CODE_N-1:0];
            mode_d = wdata[CODE_MODE_BIT];
        end
        if (|stb) bits_d = mode_q ? (bits_d | stb) : stb;
    end

    // Store registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            mode_q <= 1'b0;
        end else begin
            bits_q <= bits_d;
            mode_q <= mode_d;
        end
    end

    assign code_o    = {mode_q, bits_q};
    assign any_err_o = |stb;
endmodule

// File: rtl/err_flag_bank.sv
// Sticky error-factor flags with their enables and the interrupt enable.
// Flags clear on write-0 and keep on write-1, and events win over a
// same-cycle clear. Only the summary bit of the interrupt-enable register
// is stored.
module err_flag_bank
    import can_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             factor_we,
    input  logic             enable_we,
    input  logic             ier_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] events,
    output logic [REG_W-1:0] flags_o,
    output logic [REG_W-1:0] enable_o,
    output logic             ier_o,
    output logic             summary_o,
    output logic             irq_o
);
    logic [REG_W-1:0] flags_q, enable_q;
    logic             ier_q;

    // Flag, enable and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q  <= '0;
            enable_q <= '0;
            ier_q    <= 1'b0;
        end else begin
            flags_q <= (factor_we ? (flags_q & wdata) : flags_q) | events;
            if (enable_we) enable_q <= wdata;
            if (ier_we)    ier_q    <= wdata[IRQ_BIT];
        end
    end

    assign flags_o   = flags_q;
    assign enable_o  = enable_q;
    assign ier_o     = ier_q;
    assign summary_o = |(flags_q & enable_q);
    assign irq_o     = summary_o & ier_q;
endmodule

// File: rtl/can_err_irq_unit.sv
// CAN error flag and interrupt unit (top).
// Collects protocol-engine error strobes into the factor register and the
// code store. Runs the transmit and receive error counters and their
// threshold events. Provides a combinational register read port and the
// summary error interrupt. Assumes single-cycle strobes and synchronous
// active-low reset.
module can_err_irq_unit
    import can_err_pkg::*;
#(
    parameter int TX_STEP    = 8,
    parameter int RX_STEP    = 1,
    parameter int WARN_LIM   = 96,
    parameter int PASS_LIM   = 127,
    parameter int BUSOFF_LIM = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [2:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ev_bus_lock,
    input  logic              ev_overload,
    input  logic              ev_rx_overrun,
    input  logic              ev_bo_recover,
    input  logic [CODE_N-1:0] code_stb,
    input  logic              tx_inc,
    input  logic              tx_dec,
    input  logic              rx_inc,
    input  logic              rx_dec,
    output logic              err_irq
);
    localparam int CNT_W = $clog2(BUSOFF_LIM + 1) + 1;
    localparam logic [CNT_W-1:0] RD_MAX = CNT_W'((1 << REG_W) - 1);

    logic [CNT_W-1:0] tec, rec;
    logic tx_warn, tx_pass, tx_bo, rx_warn, rx_pass, rx_bo;
    logic [REG_W-1:0] code_q, flags_q, enable_q, events;
    logic any_code, ier_q, summary;
    logic factor_we, enable_we, code_we, ier_we;

    // Write decode.
    always_comb begin
        factor_we = wr_en && (wr_addr == A_FACTOR);
        enable_we = wr_en && (wr_addr == A_ENABLE);
        code_we   = wr_en && (wr_addr == A_CODE);
        ier_we    = wr_en && (wr_addr == A_IER);
    end

    err_counter #(
        .CNT_W(CNT_W), .STEP(TX_STEP), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .BUSOFF_LIM(BUSOFF_LIM), .BUSOFF_EN(1'b1)
    ) i_tx_cnt (
        .clk(clk), .rst_n(rst_n), .inc(tx_inc), .dec(tx_dec),
        .clr(ev_bo_recover), .cnt_o(tec), .warn_rise_o(tx_warn),
        .pass_rise_o(tx_pass), .busoff_rise_o(tx_bo)
    );

    err_counter #(
        .CNT_W(CNT_W), .STEP(RX_STEP), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .BUSOFF_LIM(BUSOFF_LIM), .BUSOFF_EN(1'b0)
    ) i_rx_cnt (
        .clk(clk), .rst_n(rst_n), .inc(rx_inc), .dec(rx_dec),
        .clr(ev_bo_recover), .cnt_o(rec), .warn_rise_o(rx_warn),
        .pass_rise_o(rx_pass), .busoff_rise_o(rx_bo)
    );

    err_code_store i_codes (
        .clk(clk), .rst_n(rst_n), .we(code_we), .wdata(wr_data),
        .stb(code_stb), .code_o(code_q), .any_err_o(any_code)
    );

    // Event vector in factor bit layout.
    always_comb begin
        events              = '0;
        events[FB_BUSERR]   = any_code;
        events[FB_WARN]     = tx_warn | rx_warn;
        events[FB_PASSIVE]  = tx_pass | rx_pass;
        events[FB_BUSOFF]   = tx_bo | rx_bo;
        events[FB_RECOVER]  = ev_bo_recover;
        events[FB_OVERRUN]  = ev_rx_overrun;
        events[FB_OVERLD]   = ev_overload;
        events[FB_BUSLOCK]  = ev_bus_lock;
    end

    err_flag_bank i_flags (
        .clk(clk), .rst_n(rst_n), .factor_we(factor_we),
        .enable_we(enable_we), .ier_we(ier_we), .wdata(wr_data),
        .events(events), .flags_o(flags_q), .enable_o(enable_q),
        .ier_o(ier_q), .summary_o(summary), .irq_o(err_irq)
    );

    // Read multiplexer, counters limited to the register width.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_FACTOR: rd_data = flags_q;
            A_ENABLE: rd_data = enable_q;
            A_CODE:   rd_data = code_q;
            A_IER:    rd_data[IRQ_BIT] = ier_q;
            A_STATUS: rd_data[IRQ_BIT] = summary;
            A_TEC:    rd_data = (tec > RD_MAX) ? '1 : tec[REG_W-1:0];
            A_REC:    rd_data = (rec > RD_MAX) ? '1 : rec[REG_W-1:0];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/can_err_irq_chk.sv
// Property checker for can_err_irq_unit, attached by bind below.
module can_err_irq_chk
    import can_err_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic              ev_rx_overrun,
    input logic [CODE_N-1:0] code_stb,
    input logic [REG_W-1:0]  flags,
    input logic [REG_W-1:0]  enables,
    input logic              ier,
    input logic [REG_W-1:0]  codes,
    input logic [CNT_W-1:0]  tec,
    input logic              err_irq
);
    localparam logic [CNT_W-1:0] BO = CNT_W'(255);

    // R3: without a factor write, no set flag is lost
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_FACTOR) |=> ((flags & $past(flags)) == $past(flags)));

    // R4: an overrun event sets its flag even against a clear
    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> flags[FB_OVERRUN]);

    // R5: any code strobe sets the bus-error flag
    p_bus_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|code_stb) |=> flags[FB_BUSERR]);

    // R6: latest-only mode replaces the stored codes
    p_latest_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|code_stb) && !codes[CODE_MODE_BIT] && !(wr_en && wr_addr == A_CODE))
        |=> (codes[CODE_N-1:0] == $past(code_stb)));

    // R10: transmit counter crossing 255 has set the bus-off flag
    p_busoff_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((tec > BO) && ($past(tec) <= BO)) |-> flags[FB_BUSOFF]);

    // R11: interrupt low unless an enabled flag and the enable bit are set
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags & enables) == '0) || !ier) |-> !err_irq);
endmodule

bind can_err_irq_unit can_err_irq_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .ev_rx_overrun(ev_rx_overrun), .code_stb(code_stb), .flags(flags_q),
    .enables(enable_q), .ier(ier_q), .codes(code_q), .tec(tec),
    .err_irq(err_irq)
);

// File: tb/test_can_err_irq_unit.sv
// Directed bench for can_err_irq_unit: one task per scenario.
module test_can_err_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ev_bus_lock = 0, ev_overload = 0, ev_rx_overrun = 0, ev_bo_recover = 0;
    logic [6:0] code_stb = '0;
    logic       tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0;
    logic       err_irq;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    can_err_irq_unit i_can_err_irq_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_bus_lock(ev_bus_lock), .ev_overload(ev_overload),
        .ev_rx_overrun(ev_rx_overrun), .ev_bo_recover(ev_bo_recover),
        .code_stb(code_stb), .tx_inc(tx_inc), .tx_dec(tx_dec),
        .rx_inc(rx_inc), .rx_dec(rx_dec), .err_irq(err_irq)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic cnt_step(input bit ti, input bit td, input bit ri, input bit rd, input int n);
        tx_inc = ti; tx_dec = td; rx_inc = ri; rx_dec = rd;
        repeat (n) tick();
        tx_inc = 0; tx_dec = 0; rx_inc = 0; rx_dec = 0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 7; a++) rd_chk("R1 reset", 3'(a), 8'h00);
        chk("R1 irq", {7'd0, err_irq}, 8'h00);
    endtask

    task automatic t_flags();
        ev_bus_lock = 1; tick(); ev_bus_lock = 0;
        rd_chk("R2 bus lock bit7", 3'd0, 8'h80);
        ev_overload = 1; tick(); ev_overload = 0;
        ev_rx_overrun = 1; tick(); ev_rx_overrun = 0;
        rd_chk("R2 overload+overrun", 3'd0, 8'hE0);
        tick();
        rd_chk("R2 sticky", 3'd0, 8'hE0);
        chk("R11 irq disabled", {7'd0, err_irq}, 8'h00);
    endtask

    task automatic t_clear();
        wr(3'd0, 8'hDF);
        rd_chk("R3 clear one bit", 3'd0, 8'hC0);
        wr(3'd0, 8'hFF);
        rd_chk("R3 write ones keeps", 3'd0, 8'hC0);
        wr(3'd0, 8'h00);
        rd_chk("R3 clear all", 3'd0, 8'h00);
    endtask

    task automatic t_event_wins();
        ev_rx_overrun = 1; wr_en = 1; wr_addr = 3'd0; wr_data = 8'h00;
        tick();
        ev_rx_overrun = 0; wr_en = 0;
        rd_chk("R4 event beats clear", 3'd0, 8'h20);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_codes();
        code_stb = 7'h08; tick(); code_stb = 0;
        rd_chk("R5 crc code", 3'd2, 8'h08);
        rd_chk("R5 bus error flag", 3'd0, 8'h01);
        code_stb = 7'h02; tick(); code_stb = 0;
        rd_chk("R6 latest replaces", 3'd2, 8'h02);
        wr(3'd2, 8'h80);
        rd_chk("R6 mode set codes cleared", 3'd2, 8'h80);
        code_stb = 7'h01; tick(); code_stb = 0;
        code_stb = 7'h04; tick(); code_stb = 0;
        rd_chk("R6 accumulate", 3'd2, 8'h85);
        wr(3'd2, 8'hFB);
        rd_chk("R3 code clear ack", 3'd2, 8'h81);
        wr(3'd2, 8'h00);
        rd_chk("R6 back to latest", 3'd2, 8'h00);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_irq();
        wr(3'd1, 8'h01);
        wr(3'd3, 8'hFF);
        rd_chk("R11 ier keeps bit5", 3'd3, 8'h20);
        rd_chk("R11 status idle", 3'd4, 8'h00);
        code_stb = 7'h40; tick(); code_stb = 0;
        rd_chk("R11 status set", 3'd4, 8'h20);
        chk("R11 irq high", {7'd0, err_irq}, 8'h01);
        wr(3'd3, 8'h00);
        chk("R11 irq gated", {7'd0, err_irq}, 8'h00);
        rd_chk("R11 status stays", 3'd4, 8'h20);
        wr(3'd1, 8'hFE);
        rd_chk("R11 status masked", 3'd4, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_rx_warn();
        cnt_step(0, 0, 1, 0, 96);
        rd_chk("R7 rec count", 3'd6, 8'd96);
        rd_chk("R8 no warn at 96", 3'd0, 8'h00);
        cnt_step(0, 0, 1, 0, 1);
        rd_chk("R8 warn at 97", 3'd0, 8'h02);
        wr(3'd0, 8'hFD);
        cnt_step(0, 0, 1, 0, 1);
        rd_chk("R8 no repeat above limit", 3'd0, 8'h00);
        cnt_step(0, 0, 0, 1, 2);
        rd_chk("R7 rec dec", 3'd6, 8'd96);
        cnt_step(0, 0, 1, 0, 1);
        rd_chk("R8 warn re-crossing", 3'd0, 8'h02);
    endtask

    task automatic t_tx();
        ev_bo_recover = 1; tick(); ev_bo_recover = 0;
        rd_chk("R7 recovery clears rec", 3'd6, 8'd0);
        rd_chk("R7 recovery flag", 3'd0, 8'h12);
        wr(3'd0, 8'h00);
        cnt_step(0, 0, 0, 1, 1);
        rd_chk("R7 rec floor", 3'd6, 8'd0);
        cnt_step(1, 0, 0, 0, 12);
        rd_chk("R7 tec step 8", 3'd5, 8'd96);
        rd_chk("R8 tx no warn", 3'd0, 8'h00);
        cnt_step(1, 0, 0, 0, 1);
        rd_chk("R8 tx warn", 3'd0, 8'h02);
        wr(3'd0, 8'h00);
        cnt_step(1, 0, 0, 0, 2);
        rd_chk("R9 no passive at 120", 3'd0, 8'h00);
        cnt_step(1, 0, 0, 0, 1);
        rd_chk("R9 passive at 128", 3'd0, 8'h04);
        wr(3'd0, 8'h00);
        cnt_step(1, 0, 0, 0, 15);
        rd_chk("R10 no bus-off at 248", 3'd0, 8'h00);
        cnt_step(1, 0, 0, 0, 1);
        rd_chk("R10 bus-off at 256", 3'd0, 8'h08);
        rd_chk("R7 tec read limited", 3'd5, 8'hFF);
        ev_bo_recover = 1; tick(); ev_bo_recover = 0;
        rd_chk("R7 tec cleared", 3'd5, 8'd0);
        cnt_step(1, 1, 0, 0, 1);
        rd_chk("R7 inc and dec together", 3'd5, 8'd7);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        t_reset();
        t_flags();
        t_clear();
        t_event_wins();
        t_codes();
        t_irq();
        t_rx_warn();
        t_tx();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule